// File: doc/BRIEF.md
# Convolution Engine Bus Hub

This block is a Wishbone slave that places several convolution engine instances behind one 32-bit address space. The address is taken relative to a fixed base. The byte above the 24-bit instance span picks the instance. Inside each instance there are four 256-byte windows: a control window with three registers, an image store, a kernel store and a result store. Each window holds 32-bit words at a 4-byte stride.

The bus can write the control registers and the image and kernel stores. It can read the control registers, including the live completion flag from the engine, and the result store. Every access gets exactly one acknowledge. This includes accesses to an instance that does not exist or to an unmapped offset.

The engines themselves are outside this block. Each engine sees the following:
- its start and soft-reset bits;
- its two packed configuration words;
- a shared read address into its image and kernel stores;
- a shared write port into its own result store, selected per instance.

All instances share the bus clock and the synchronous reset.

Top module: `convBusHub`

## Requirements
- R1: The acknowledge rises on the clock edge after the edge at which cyc and stb are first seen high. It lasts exactly one cycle. It never rises unless cyc and stb were high at the previous edge. A write takes effect at the same edge at which the acknowledge rises.
- R2: The instance is bits [31:24] of (address − 0x3000_0000). If that instance number is not below the instance count, or if bits [23:10] of the relative address are not zero, the access is still acknowledged. It then reads 0 and writes nothing.
- R3: Relative address bits [9:8] pick the window: 0 for control, 1 for image, 2 for kernel, 3 for result. Bits [7:2] pick the word inside the window.
- R4: In control word 0, bit 0 reads the engine's done input, bit 1 is soft reset and bit 2 is start. Bits 1 and 2 are driven to the engine. A write to bit 0 has no effect, and the other bits read 0.
- R5: Control word 1 keeps only bits [2:0], [15:8], [18:16] and [31:24] (kernel length, columns, kernel count, stride). All other bits read 0 and drive 0 on the configuration output.
- R6: Control word 2 keeps only bits [7:0], [11:8], 16, 17 and [20:18] (result count, shift, kernel addressing mode, pooling enable, channel mask). All other bits read 0 and drive 0.
- R7: Writes to the image or kernel window store data bits [23:0] at the word index. The engine reads that value through its read port. Bus reads of these windows return 0.
- R8: Result words are written only by the engine port. A bus read returns the 8-bit entry zero-extended to 32 bits. Bus writes to the result window are ignored.
- R9: Reset clears start, soft reset and both configuration words in every instance, and drops the acknowledge.
- R10: Control words 3 to 63 are unmapped. They read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and engine clock |
| rst | input | 1 | Synchronous active-high reset |
| wbCyc | input | 1 | Bus cycle |
| wbStb | input | 1 | Bus strobe |
| wbWe | input | 1 | Write enable |
| wbAdr | input | 32 | Byte address |
| wbDatW | input | 32 | Write data |
| wbAck | output | 1 | Acknowledge, one cycle per access |
| wbDatR | output | 32 | Read data, valid with wbAck |
| engDone | input | N_INST | Done flag from each engine |
| engStart | output | N_INST | Start bit per instance |
| engSoftRst | output | N_INST | Soft reset bit per instance |
| engCfgA | output | 32*N_INST | Masked control word 1 per instance |
| engCfgB | output | 32*N_INST | Masked control word 2 per instance |
| engMemAddr | input | 6 | Engine read word index, shared |
| engImgData | output | 24*N_INST | Image word at engMemAddr per instance |
| engKernData | output | 24*N_INST | Kernel word at engMemAddr per instance |
| engResWe | input | N_INST | Result write enable per instance |
| engResAddr | input | 6 | Result write word index |
| engResData | input | 8 | Result write value |

## Verification
The hardest cases to reach are the addresses that look valid but decode as unmapped, because each one needs a particular combination of address fields. These are:
- an instance number just past the count;
- an address below the base, which wraps to a huge instance number;
- stray bits in [23:10];
- control words above 2.

The random traffic draws instance numbers up to two past the count and control word indices up to 4. Directed accesses add the wrap-around and stray-bit cases. After each unmapped write, the bench reads the engine outputs and the stores through the engine port to show that nothing changed.

// File: rtl/conv_hub_pkg.sv
package conv_hub_pkg;
  localparam int WIN_BYTES = 256;
  localparam int WIN_WORDS = WIN_BYTES / 4;
  localparam int IDX_W = $clog2(WIN_WORDS);
  localparam logic [31:0] CFG_A_MASK = 32'hFF07_FF07;
  localparam logic [31:0] CFG_B_MASK = 32'h001F_0FFF;

  typedef enum logic [1:0] {
    RG_CTRL = 2'd0,
    RG_IMG  = 2'd1,
    RG_KERN = 2'd2,
    RG_RES  = 2'd3
  } region_e;

  typedef struct packed {
    logic             accept;
    logic             write;
    logic             hit;
    region_e          region;
    logic [7:0]       inst;
    logic [IDX_W-1:0] word;
  } busCmd_t;
endpackage

// File: rtl/hubCtrl.sv
module hubCtrl
  import conv_hub_pkg::*;
#(
  parameter int          N_INST    = 4,
  parameter logic [31:0] BASE_ADDR = 32'h3000_0000
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wbCyc,
  input  logic        wbStb,
  input  logic        wbWe,
  input  logic [31:0] wbAdr,
  output logic        wbAck,
  output busCmd_t     cmd
);
  logic [31:0] relAdr;
  logic        instOk, spanOk, regOk;
  region_e     region;

  always_comb begin
    relAdr = wbAdr - BASE_ADDR;
    region = region_e'(relAdr[9:8]);
    instOk = ({24'd0, relAdr[31:24]} < N_INST);
    spanOk = (relAdr[23:10] == '0);
    regOk  = (region != RG_CTRL) || (relAdr[7:2] <= 6'd2);
    cmd.accept = wbCyc && wbStb && !wbAck;
    cmd.write  = wbWe;
    cmd.hit    = instOk && spanOk && regOk;
    cmd.region = region;
    cmd.inst   = relAdr[31:24];
    cmd.word   = relAdr[IDX_W+1:2];
  end

  always_ff @(posedge clk) begin
    if (rst) wbAck <= 1'b0;
    else     wbAck <= cmd.accept;
  end

  p_ack_single_r1: assert property (@(posedge clk) disable iff (rst)
    wbAck |=> !wbAck);
  p_ack_caused_r1: assert property (@(posedge clk) disable iff (rst)
    $rose(wbAck) |-> $past(wbCyc && wbStb));
  p_ack_follows_r1: assert property (@(posedge clk) disable iff (rst)
    (wbCyc && wbStb && !wbAck) |=> wbAck);
  p_idle_no_ack_r1: assert property (@(posedge clk) disable iff (rst)
    !(wbCyc && wbStb) |=> !wbAck);
endmodule

// File: rtl/hubStore.sv
module hubStore
  import conv_hub_pkg::*;
#(
  parameter int N_INST = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  busCmd_t                cmd,
  input  logic [31:0]            wrData,
  output logic [31:0]            rdData,
  input  logic [N_INST-1:0]      engDone,
  output logic [N_INST-1:0]      engStart,
  output logic [N_INST-1:0]      engSoftRst,
  output logic [N_INST*32-1:0]   engCfgA,
  output logic [N_INST*32-1:0]   engCfgB,
  input  logic [IDX_W-1:0]       engMemAddr,
  output logic [N_INST*24-1:0]   engImgData,
  output logic [N_INST*24-1:0]   engKernData,
  input  logic [N_INST-1:0]      engResWe,
  input  logic [IDX_W-1:0]       engResAddr,
  input  logic [7:0]             engResData
);
  localparam int INST_W = (N_INST > 1) ? $clog2(N_INST) : 1;

  logic [N_INST-1:0][31:0] rdWordAll;

  for (genvar gi = 0; gi < N_INST; gi++) begin : g_inst
    logic [23:0] imgMem  [WIN_WORDS];
    logic [23:0] kernMem [WIN_WORDS];
    logic [7:0]  resMem  [WIN_WORDS];
    logic        startQ, softQ;
    logic [31:0] cfgAQ, cfgBQ;
    logic        wrHere;

    assign wrHere = cmd.accept && cmd.write && cmd.hit && (cmd.inst == 8'(gi));

    always_ff @(posedge clk) begin
      if (rst) begin
        startQ <= 1'b0;
        softQ  <= 1'b0;
        cfgAQ  <= '0;
        cfgBQ  <= '0;
      end else if (wrHere && cmd.region == RG_CTRL) begin
        case (cmd.word)
          6'd0: begin
            softQ  <= wrData[1];
            startQ <= wrData[2];
          end
          6'd1:    cfgAQ <= wrData & CFG_A_MASK;
          6'd2:    cfgBQ <= wrData & CFG_B_MASK;
          default: ;
        endcase
      end
    end

    always_ff @(posedge clk) begin
      if (wrHere && cmd.region == RG_IMG)  imgMem[cmd.word]  <= wrData[23:0];
      if (wrHere && cmd.region == RG_KERN) kernMem[cmd.word] <= wrData[23:0];
      if (engResWe[gi])                    resMem[engResAddr] <= engResData;
    end

    always_comb begin
      rdWordAll[gi] = '0;
      case (cmd.region)
        RG_CTRL: begin
          if (cmd.word == 6'd0)      rdWordAll[gi] = {29'd0, startQ, softQ, engDone[gi]};
          else if (cmd.word == 6'd1) rdWordAll[gi] = cfgAQ;
          else if (cmd.word == 6'd2) rdWordAll[gi] = cfgBQ;
        end
        RG_RES:  rdWordAll[gi] = {24'd0, resMem[cmd.word]};
        default: rdWordAll[gi] = '0;
      endcase
    end

    assign engStart[gi]          = startQ;
    assign engSoftRst[gi]        = softQ;
    assign engCfgA[gi*32 +: 32]  = cfgAQ;
    assign engCfgB[gi*32 +: 32]  = cfgBQ;
    assign engImgData[gi*24 +: 24]  = imgMem[engMemAddr];
    assign engKernData[gi*24 +: 24] = kernMem[engMemAddr];
  end

  always_ff @(posedge clk) begin
    if (rst) rdData <= '0;
    else if (cmd.accept)
      rdData <= (cmd.hit && !cmd.write) ? rdWordAll[cmd.inst[INST_W-1:0]] : '0;
  end

  p_write_reads_zero_r7: assert property (@(posedge clk) disable iff (rst)
    (cmd.accept && cmd.write) |=> (rdData == '0));
  p_miss_reads_zero_r2: assert property (@(posedge clk) disable iff (rst)
    (cmd.accept && !cmd.hit) |=> (rdData == '0));
  p_cfg_reserved_r5: assert property (@(posedge clk) disable iff (rst)
    ((engCfgA & ~{N_INST{CFG_A_MASK}}) == '0) && ((engCfgB & ~{N_INST{CFG_B_MASK}}) == '0));
endmodule

// File: rtl/convBusHub.sv
module convBusHub
  import conv_hub_pkg::*;
#(
  parameter int          N_INST    = 4,
  parameter logic [31:0] BASE_ADDR = 32'h3000_0000
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wbCyc,
  input  logic                  wbStb,
  input  logic                  wbWe,
  input  logic [31:0]           wbAdr,
  input  logic [31:0]           wbDatW,
  output logic                  wbAck,
  output logic [31:0]           wbDatR,
  input  logic [N_INST-1:0]     engDone,
  output logic [N_INST-1:0]     engStart,
  output logic [N_INST-1:0]     engSoftRst,
  output logic [N_INST*32-1:0]  engCfgA,
  output logic [N_INST*32-1:0]  engCfgB,
  input  logic [IDX_W-1:0]      engMemAddr,
  output logic [N_INST*24-1:0]  engImgData,
  output logic [N_INST*24-1:0]  engKernData,
  input  logic [N_INST-1:0]     engResWe,
  input  logic [IDX_W-1:0]      engResAddr,
  input  logic [7:0]            engResData
);
  busCmd_t cmd;

  hubCtrl #(.N_INST(N_INST), .BASE_ADDR(BASE_ADDR)) u_ctrl (
    .clk(clk), .rst(rst), .wbCyc(wbCyc), .wbStb(wbStb), .wbWe(wbWe),
    .wbAdr(wbAdr), .wbAck(wbAck), .cmd(cmd)
  );

  hubStore #(.N_INST(N_INST)) u_store (
    .clk(clk), .rst(rst), .cmd(cmd), .wrData(wbDatW), .rdData(wbDatR),
    .engDone(engDone), .engStart(engStart), .engSoftRst(engSoftRst),
    .engCfgA(engCfgA), .engCfgB(engCfgB), .engMemAddr(engMemAddr),
    .engImgData(engImgData), .engKernData(engKernData),
    .engResWe(engResWe), .engResAddr(engResAddr), .engResData(engResData)
  );
endmodule

// File: tb/tb_convBusHub.sv
module tb_convBusHub;
  localparam int CLK_P = 10;
  localparam int NI = 4;
  localparam logic [31:0] BASE = 32'h3000_0000;
  localparam logic [31:0] MASK_A = 32'hFF07_FF07;
  localparam logic [31:0] MASK_B = 32'h001F_0FFF;

  logic clk = 1'b0, rst = 1'b1;
  logic wbCyc = 0, wbStb = 0, wbWe = 0;
  logic [31:0] wbAdr = 0, wbDatW = 0;
  logic wbAck;
  logic [31:0] wbDatR;
  logic [NI-1:0] engDone = 0, engStart, engSoftRst, engResWe = 0;
  logic [NI*32-1:0] engCfgA, engCfgB;
  logic [5:0] engMemAddr = 0, engResAddr = 0;
  logic [NI*24-1:0] engImgData, engKernData;
  logic [7:0] engResData = 0;

  convBusHub #(.N_INST(NI), .BASE_ADDR(BASE)) dut (
    .clk(clk), .rst(rst), .wbCyc(wbCyc), .wbStb(wbStb), .wbWe(wbWe),
    .wbAdr(wbAdr), .wbDatW(wbDatW), .wbAck(wbAck), .wbDatR(wbDatR),
    .engDone(engDone), .engStart(engStart), .engSoftRst(engSoftRst),
    .engCfgA(engCfgA), .engCfgB(engCfgB), .engMemAddr(engMemAddr),
    .engImgData(engImgData), .engKernData(engKernData), .engResWe(engResWe),
    .engResAddr(engResAddr), .engResData(engResData)
  );

  always #(CLK_P/2) clk = ~clk;

  int nRun = 0, nFail = 0;
  logic mStart [NI], mSoft [NI];
  logic [31:0] mCfgA [NI], mCfgB [NI];
  logic [23:0] mImg [NI][64], mKern [NI][64];
  logic [7:0]  mRes [NI][64];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mkAdr(int inst, int region, int word);
    return BASE + (32'(inst) << 24) + (32'(region) << 8) + (32'(word) << 2);
  endfunction

  function automatic logic mapped(logic [31:0] a);
    logic [31:0] r = a - BASE;
    if ({24'd0, r[31:24]} >= NI || r[23:10] != 0) return 1'b0;
    if (r[9:8] == 2'd0 && r[7:2] > 6'd2) return 1'b0;
    return 1'b1;
  endfunction

  function automatic logic [31:0] expRead(logic [31:0] a);
    logic [31:0] r = a - BASE;
    int i = int'(r[31:24]);
    if (!mapped(a)) return 0;
    case (r[9:8])
      2'd0: case (r[7:2])
              6'd0: return {29'd0, mStart[i], mSoft[i], engDone[i]};
              6'd1: return mCfgA[i];
              default: return mCfgB[i];
            endcase
      2'd3: return {24'd0, mRes[i][r[7:2]]};
      default: return 0;
    endcase
  endfunction

  task automatic modelWrite(logic [31:0] a, logic [31:0] d);
    logic [31:0] r = a - BASE;
    int i = int'(r[31:24]);
    if (!mapped(a)) return;
    case (r[9:8])
      2'd0: case (r[7:2])
              6'd0: begin mSoft[i] = d[1]; mStart[i] = d[2]; end
              6'd1: mCfgA[i] = d & MASK_A;
              default: mCfgB[i] = d & MASK_B;
            endcase
      2'd1: mImg[i][r[7:2]] = d[23:0];
      2'd2: mKern[i][r[7:2]] = d[23:0];
      default: ;
    endcase
  endtask

  // One bus access; checks single-cycle ack (R1) and returns read data.
  task automatic xfer(input logic we, input logic [31:0] a, input logic [31:0] d,
                      output logic [31:0] rd);
    int waits = 0;
    @(negedge clk);
    wbCyc = 1; wbStb = 1; wbWe = we; wbAdr = a; wbDatW = d;
    do begin
      @(negedge clk);
      waits++;
    end while (!wbAck && waits < 20);
    chk("R1 ack latency", 32'(waits), 32'd1);
    rd = wbDatR;
    wbCyc = 0; wbStb = 0;
    @(negedge clk);
    chk("R1 ack single pulse", {31'd0, wbAck}, 32'd0);
    if (we) modelWrite(a, d);
  endtask

  task automatic busWrite(logic [31:0] a, logic [31:0] d);
    logic [31:0] junk;
    xfer(1'b1, a, d, junk);
  endtask

  task automatic busRead(string req, logic [31:0] a);
    logic [31:0] rd, e;
    e = expRead(a);
    xfer(1'b0, a, 32'd0, rd);
    chk(req, rd, e);
  endtask

  task automatic checkEngOut(string req);
    for (int i = 0; i < NI; i++) begin
      chk({req, " start"}, {31'd0, engStart[i]}, {31'd0, mStart[i]});
      chk({req, " soft"}, {31'd0, engSoftRst[i]}, {31'd0, mSoft[i]});
      chk({req, " cfgA R5"}, engCfgA[i*32 +: 32], mCfgA[i]);
      chk({req, " cfgB R6"}, engCfgB[i*32 +: 32], mCfgB[i]);
    end
  endtask

  task automatic checkStores(string req);
    for (int w = 0; w < 64; w++) begin
      @(negedge clk);
      engMemAddr = 6'(w);
      #1;
      for (int i = 0; i < NI; i++) begin
        chk({req, " img"}, {8'd0, engImgData[i*24 +: 24]}, {8'd0, mImg[i][w]});
        chk({req, " kern"}, {8'd0, engKernData[i*24 +: 24]}, {8'd0, mKern[i][w]});
      end
    end
  endtask

  task automatic engResWrite(int i, int w, logic [7:0] v);
    @(negedge clk);
    engResWe = NI'(1) << i; engResAddr = 6'(w); engResData = v;
    @(negedge clk);
    engResWe = 0;
    mRes[i][w] = v;
  endtask

  task automatic doReset();
    @(negedge clk); rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    for (int i = 0; i < NI; i++) begin
      mStart[i] = 0; mSoft[i] = 0; mCfgA[i] = 0; mCfgB[i] = 0;
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    nRun++; nFail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin : main
    logic [31:0] a, d;
    void'($urandom(32'd20240611));
    doReset();
    @(negedge clk);
    chk("R9 reset ack", {31'd0, wbAck}, 32'd0);
    checkEngOut("R9 reset");
    for (int i = 0; i < NI; i++)
      for (int r = 0; r < 3; r++) busRead("R9 reg after reset", mkAdr(i, 0, r));

    // Fill stores through both paths.
    for (int i = 0; i < NI; i++)
      for (int w = 0; w < 64; w++) begin
        busWrite(mkAdr(i, 1, w), $urandom());
        busWrite(mkAdr(i, 2, w), $urandom());
        engResWrite(i, w, 8'($urandom()));
      end
    checkStores("R7 fill");

    // Directed corners.
    busWrite(mkAdr(1, 0, 1), 32'hFFFF_FFFF);
    busRead("R5 cfgA mask", mkAdr(1, 0, 1));
    busWrite(mkAdr(2, 0, 2), 32'hFFFF_FFFF);
    busRead("R6 cfgB mask", mkAdr(2, 0, 2));
    engDone = 4'b0101;
    busWrite(mkAdr(0, 0, 0), 32'h0000_0007);
    busRead("R4 ctrl with done", mkAdr(0, 0, 0));
    busWrite(mkAdr(2, 0, 0), 32'h0000_0001);
    busRead("R4 done bit not writable", mkAdr(2, 0, 0));
    busWrite(mkAdr(3, 0, 3), 32'hFFFF_FFFF);
    busRead("R10 unmapped ctrl word", mkAdr(3, 0, 3));
    busRead("R10 ctrl word 63", mkAdr(3, 0, 63));
    busWrite(mkAdr(NI, 0, 1), 32'hFFFF_FFFF);
    busRead("R2 instance past count", mkAdr(NI, 0, 1));
    busWrite(BASE - 32'h100, 32'hFFFF_FFFF);
    busRead("R2 below base", BASE - 32'h100);
    busWrite(mkAdr(0, 0, 1) + 32'h400, 32'hFFFF_FFFF);
    busRead("R2 stray offset bits", mkAdr(0, 0, 1) + 32'h400);
    busWrite(mkAdr(1, 3, 5), 32'h0000_00AA);
    busRead("R8 result write ignored", mkAdr(1, 3, 5));
    busRead("R7 image read zero", mkAdr(1, 1, 5));
    busRead("R3 kernel read zero", mkAdr(1, 2, 9));
    busWrite(mkAdr(3, 1, 63), 32'hDEAD_BEEF);
    busWrite(mkAdr(0, 2, 0), 32'h1234_5678);
    checkEngOut("R4 directed");
    checkStores("R7 directed");

    // Random traffic.
    for (int n = 0; n < 1200; n++) begin
      int inst = $urandom_range(0, NI + 1);
      int reg_ = $urandom_range(0, 3);
      int word = (reg_ == 0) ? $urandom_range(0, 4) : $urandom_range(0, 63);
      a = mkAdr(inst, reg_, word);
      d = $urandom();
      if (n % 7 == 0) engDone = NI'($urandom());
      if (n % 11 == 0) engResWrite($urandom_range(0, NI - 1), $urandom_range(0, 63), 8'($urandom()));
      if ($urandom_range(0, 1) == 1) begin
        busWrite(a, d);
        if (reg_ == 0) checkEngOut("R4 random");
      end else
        busRead("R3 random read", a);
    end
    checkStores("R7 random");

    // Second reset after activity.
    doReset();
    @(negedge clk);
    checkEngOut("R9 second reset");
    busRead("R9 ctrl after reset", mkAdr(1, 0, 0));

    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule